// File: doc/BRIEF.md
# SPI Frame Timing Generator

This block produces the serial clock and the select window for one SPI master frame at a time. A frame begins on a one-cycle start strobe. At that strobe the block captures a 31-bit attribute word and a continuous-select flag, and it keeps both unchanged until the frame ends. The attribute word sets the frame length, the clock polarity and phase, and the bit order. It also sets the SCK rate and three programmable delays: select to first clock edge, last clock edge to deselect, and the idle gap after deselect.

Each rate and each delay is the product of two small encoded fields, not a single linear divisor.

- **SCK period:** a prescaler from {2,3,5,7} times a scaler taken from a 16-entry table.
- **Each delay:** an odd prescaler from {1,3,5,7} times 2^(n+1).

The block raises a shift strobe or a sample strobe in the same cycle that SCK shows the edge concerned. A separate data shifter uses these strobes, together with the bit-order output.

When the continuous flag is captured and the next frame is started in the cycle that `frame_done` reports, select stays active between the two frames. The deselect delay and the gap are then skipped.

Top module: `spi_frame_timer`

## Requirements
- R1: After reset, `sck`, `cs_en`, `shift_stb`, `sample_stb`, `frame_done` and `lsb_first` are all 0.
- R2: The first SCK edge appears L+H cycles after `cs_en` rises. L is the lead delay: odd prescaler 2·attr[14:13]+1 times 2^(attr[18:15]+1). H is half the SCK period, as defined in R3.
- R3: The SCK period is P×S cycles and successive edges are H=P×S/2 cycles apart. P is chosen by attr[8:7] from {2,3,5,7}. S is chosen by attr[12:9]: 2·(k+1) for k<4, and 2^k for k≥4.
- R4: A frame has 2·N SCK edges. N is attr[3:0]+1, and field values 0 to 2 are treated as N=4.
- R5: The SCK idle level is attr[4], captured at start. Edges with an odd index move SCK away from the idle level, and SCK returns to the idle level on the last edge. While `cs_en` is low, SCK does not change.
- R6: When attr[5] is 0, `sample_stb` marks every odd edge, and `shift_stb` marks every even edge except the last. When attr[5] is 1, `shift_stb` marks every odd edge and `sample_stb` marks every even edge. No strobe is raised outside an edge cycle.
- R7: `cs_en` falls T cycles after the last SCK edge. T is the odd prescaler from attr[20:19] times 2^(attr[24:21]+1).
- R8: `frame_done` is high for exactly one cycle, G−1 cycles after `cs_en` falls. G uses the same encoding on attr[26:25] and attr[30:27]. A start given in that cycle raises `cs_en` in the next cycle.
- R9: If `cont` was captured high, `frame_done` is high in the cycle of the last SCK edge. A start given then keeps `cs_en` high, and the new frame's first edge comes H'+1 cycles later, where H' is the new frame's half period.
- R10: If `cont` was captured high and no start follows, `cs_en` falls T+1 cycles after the last SCK edge. The gap then follows as in R8.
- R11: A start is honoured only while idle or while `frame_done` is high. Changes on `attr` or `cont` after capture have no effect on the frame in progress.
- R12: `lsb_first` equals attr[6] as captured at the most recent start, and holds that value after the frame ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Frame-start strobe |
| attr | input | 31 | Frame attribute word |
| cont | input | 1 | Keep select active into the next frame |
| sck | output | 1 | Serial clock |
| cs_en | output | 1 | Chip-select active enable |
| shift_stb | output | 1 | Drive the next data bit |
| sample_stb | output | 1 | Capture the incoming data bit |
| frame_done | output | 1 | Ready to accept the next start |
| lsb_first | output | 1 | Captured bit-order selection |

## Verification
The bench measures every edge time and every strobe against the decoded fields. It uses both phases, both polarities, a clamped short frame, a 16-bit frame and large scaler entries.

- **Decode errors:** a scaler or prescaler decoded wrongly shows up as shifted edge spacing. An off-by-one delay counter moves the select-to-edge or deselect cycle by one.
- **Start handling:** junk starts and junk attribute values are applied in the middle of a frame. A block that re-captured the attribute word would change the edge pattern.
- **Frame boundaries:** the continuous hold with a follow-on start, the hold with no follow-on start, and a back-to-back start in the done cycle are each timed exactly. A block that dropped select, or that wrongly kept the gap, would miss those cycles.

// File: rtl/spi_frame_timer.sv
module spi_frame_timer #(
  parameter int CNT_W = 20
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [30:0] attr,
  input  logic        cont,
  output logic        sck,
  output logic        cs_en,
  output logic        shift_stb,
  output logic        sample_stb,
  output logic        frame_done,
  output logic        lsb_first
);
  localparam int EDGE_W = 6;

  typedef enum logic [2:0] {S_IDLE, S_LEAD, S_XFER, S_HOLD, S_TRAIL, S_GAP} state_t;

  function automatic logic [CNT_W-1:0] half_of(input logic [1:0] p, input logic [3:0] s);
    logic [CNT_W-1:0] pr, sc;
    case (p)
      2'd0: pr = CNT_W'(2);
      2'd1: pr = CNT_W'(3);
      2'd2: pr = CNT_W'(5);
      default: pr = CNT_W'(7);
    endcase
    sc = (s < 4'd4) ? CNT_W'({s, 1'b0} + 5'd2) : (CNT_W'(1) << s);
    return (pr * sc) >> 1;
  endfunction

  function automatic logic [CNT_W-1:0] delay_of(input logic [1:0] p, input logic [3:0] n);
    return CNT_W'({p, 1'b1}) << ({1'b0, n} + 5'd1);
  endfunction

  state_t              state_q;
  logic [CNT_W-1:0]    cnt_q;
  logic [EDGE_W-1:0]   edges_q;
  logic                cpha_q, cont_q;
  logic [1:0]          bp_q, tp_q, gp_q;
  logic [3:0]          bs_q, tn_q, gn_q;

  logic                take;
  logic [EDGE_W-1:0]   in_edges;
  logic [CNT_W-1:0]    in_half, in_lead, cur_half, cur_trail, cur_gap;

  assign in_edges  = (attr[3:0] < 4'd3) ? EDGE_W'(8)
                                        : (EDGE_W'({1'b0, attr[3:0]} + 5'd1) << 1);
  assign in_half   = half_of(attr[8:7], attr[12:9]);
  assign in_lead   = delay_of(attr[14:13], attr[18:15]);
  assign cur_half  = half_of(bp_q, bs_q);
  assign cur_trail = delay_of(tp_q, tn_q);
  assign cur_gap   = delay_of(gp_q, gn_q);

  assign frame_done = (state_q == S_HOLD) || (state_q == S_GAP && cnt_q == '0);
  assign take       = start && (state_q == S_IDLE || frame_done);
  assign cs_en      = (state_q == S_LEAD) || (state_q == S_XFER) ||
                      (state_q == S_HOLD) || (state_q == S_TRAIL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpha_q <= 1'b0; cont_q <= 1'b0; lsb_first <= 1'b0;
      bp_q <= '0; bs_q <= '0; tp_q <= '0; tn_q <= '0; gp_q <= '0; gn_q <= '0;
    end else if (take) begin
      cpha_q    <= attr[5];
      lsb_first <= attr[6];
      cont_q    <= cont;
      bp_q <= attr[8:7];   bs_q <= attr[12:9];
      tp_q <= attr[20:19]; tn_q <= attr[24:21];
      gp_q <= attr[26:25]; gn_q <= attr[30:27];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= S_IDLE;
      cnt_q      <= '0;
      edges_q    <= '0;
      sck        <= 1'b0;
      shift_stb  <= 1'b0;
      sample_stb <= 1'b0;
    end else begin
      shift_stb  <= 1'b0;
      sample_stb <= 1'b0;
      if (take) begin
        sck     <= attr[4];
        edges_q <= in_edges;
      end
      case (state_q)
        S_IDLE: begin
          if (take) begin
            state_q <= S_LEAD;
            cnt_q   <= in_lead - 1'b1;
          end
        end
        S_LEAD: begin
          if (cnt_q == '0) begin
            state_q <= S_XFER;
            cnt_q   <= cur_half - 1'b1;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        S_XFER: begin
          if (cnt_q == '0) begin
            sck        <= ~sck;
            sample_stb <= cpha_q ? edges_q[0] : ~edges_q[0];
            shift_stb  <= cpha_q ? ~edges_q[0] : (edges_q[0] && edges_q != EDGE_W'(1));
            edges_q    <= edges_q - 1'b1;
            if (edges_q == EDGE_W'(1)) begin
              state_q <= cont_q ? S_HOLD : S_TRAIL;
              cnt_q   <= cur_trail - 1'b1;
            end else begin
              cnt_q <= cur_half - 1'b1;
            end
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        S_HOLD: begin
          if (take) begin
            state_q <= S_XFER;
            cnt_q   <= in_half - 1'b1;
          end else begin
            state_q <= S_TRAIL;
            cnt_q   <= cur_trail - 1'b1;
          end
        end
        S_TRAIL: begin
          if (cnt_q == '0) begin
            state_q <= S_GAP;
            cnt_q   <= cur_gap - 1'b1;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        S_GAP: begin
          if (cnt_q == '0) begin
            if (take) begin
              state_q <= S_LEAD;
              cnt_q   <= in_lead - 1'b1;
            end else begin
              state_q <= S_IDLE;
            end
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_frame_timer_chk.sv
module spi_frame_timer_chk (
  input logic clk,
  input logic rst_n,
  input logic sck,
  input logic cs_en,
  input logic shift_stb,
  input logic sample_stb,
  input logic frame_done
);
  a_r6_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(shift_stb && sample_stb));

  a_r6_strobe_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_stb || sample_stb) |-> (sck != $past(sck)));

  a_r5_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_en |-> $stable(sck));

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);

  a_r7_strobe_in_select: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_stb || sample_stb) |-> cs_en);
endmodule

bind spi_frame_timer spi_frame_timer_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sck        (sck),
  .cs_en      (cs_en),
  .shift_stb  (shift_stb),
  .sample_stb (sample_stb),
  .frame_done (frame_done)
);

// File: tb/spi_frame_timer_bench.sv
`timescale 1ns/1ps
module spi_frame_timer_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [30:0] attr = '0;
  logic cont = 1'b0;
  logic sck, cs_en, shift_stb, sample_stb, frame_done, lsb_first;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  int n_edge, n_rise, n_fall, n_done, stray;
  int edge_t [128];
  bit edge_v [128];
  bit edge_s [128];
  bit edge_h [128];
  int rise_t [4];
  int fall_t [4];
  int done_t [4];

  always #2.5 clk = ~clk;

  spi_frame_timer u_spi_frame_timer (
    .clk(clk), .rst_n(rst_n), .start(start), .attr(attr), .cont(cont),
    .sck(sck), .cs_en(cs_en), .shift_stb(shift_stb), .sample_stb(sample_stb),
    .frame_done(frame_done), .lsb_first(lsb_first)
  );

  function automatic logic [30:0] mk(int fsz, int cpol, int cpha, int lsb, int bp, int bs,
                                     int lp, int ln, int tp, int tn, int gp, int gn);
    logic [31:0] w;
    w = 32'(fsz) | (32'(cpol) << 4) | (32'(cpha) << 5) | (32'(lsb) << 6) |
        (32'(bp) << 7) | (32'(bs) << 9) | (32'(lp) << 13) | (32'(ln) << 15) |
        (32'(tp) << 19) | (32'(tn) << 21) | (32'(gp) << 25) | (32'(gn) << 27);
    return w[30:0];
  endfunction

  function automatic int f_bits(logic [30:0] a);
    return (int'(a[3:0]) < 3) ? 4 : int'(a[3:0]) + 1;
  endfunction
  function automatic int f_half(logic [30:0] a);
    int pre_t[4] = '{2, 3, 5, 7};
    int k = int'(a[12:9]);
    int s = (k < 4) ? 2 * (k + 1) : (1 << k);
    return pre_t[a[8:7]] * s / 2;
  endfunction
  function automatic int f_dly(logic [1:0] p, logic [3:0] n);
    int pre_t[4] = '{1, 3, 5, 7};
    return pre_t[p] * (2 << int'(n));
  endfunction
  function automatic int f_lead(logic [30:0] a);  return f_dly(a[14:13], a[18:15]); endfunction
  function automatic int f_trail(logic [30:0] a); return f_dly(a[20:19], a[24:21]); endfunction
  function automatic int f_gap(logic [30:0] a);   return f_dly(a[26:25], a[30:27]); endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic run(input logic [30:0] a, input logic c, input int ncyc, input int inj_t,
                     input bit follow, input logic [30:0] a2, input logic c2);
    logic ps, pc;
    n_edge = 0; n_rise = 0; n_fall = 0; n_done = 0; stray = 0;
    @(negedge clk);
    ps = sck; pc = cs_en;
    start = 1'b1; attr = a; cont = c;
    for (int t = 1; t <= ncyc; t++) begin
      @(negedge clk);
      start = 1'b0; attr = ~a; cont = ~c;
      if (cs_en && !pc && n_rise < 4) begin rise_t[n_rise] = t; n_rise++; end
      if (!cs_en && pc && n_fall < 4) begin fall_t[n_fall] = t; n_fall++; end
      if (sck != ps && pc) begin
        if (n_edge < 128) begin
          edge_t[n_edge] = t; edge_v[n_edge] = sck;
          edge_s[n_edge] = sample_stb; edge_h[n_edge] = shift_stb;
        end
        n_edge++;
      end else if (sample_stb || shift_stb) begin
        stray++;
      end
      if (frame_done) begin
        if (n_done < 4) done_t[n_done] = t;
        if (n_done == 0 && follow) begin start = 1'b1; attr = a2; cont = c2; end
        n_done++;
      end
      if (t == inj_t) start = 1'b1;
      ps = sck; pc = cs_en;
    end
  endtask

  task automatic check_edges(input string tag, input int first, input int nb, input int t0,
                             input int h, input logic cpol, input logic cpha);
    int bt = 0, bv = 0, bs = 0;
    for (int k = 0; k < 2 * nb; k++) begin
      int idx = first + k;
      bit odd = (k % 2 == 0);
      bit es = cpha ? !odd : odd;
      bit eh = cpha ? odd : (!odd && k != 2 * nb - 1);
      bit ev = odd ? !cpol : cpol;
      if (idx >= n_edge || idx >= 128) begin bt++; bv++; bs++; end
      else begin
        if (edge_t[idx] != t0 + k * h) bt++;
        if (edge_v[idx] != ev) bv++;
        if (edge_s[idx] != es || edge_h[idx] != eh) bs++;
      end
    end
    chk("R3", {tag, " edge timing mismatches"}, bt, 0);
    chk("R5", {tag, " edge level mismatches"}, bv, 0);
    chk("R6", {tag, " strobe mismatches"}, bs, 0);
  endtask

  task automatic t_reset();
    chk("R1", "sck after reset", int'(sck), 0);
    chk("R1", "cs_en after reset", int'(cs_en), 0);
    chk("R1", "strobes after reset", int'(shift_stb) + int'(sample_stb), 0);
    chk("R1", "frame_done after reset", int'(frame_done), 0);
    chk("R1", "lsb_first after reset", int'(lsb_first), 0);
  endtask

  task automatic t_single(input string tag, input logic [30:0] a, input int inj_t);
    int b = f_bits(a), h = f_half(a), l = f_lead(a), tr = f_trail(a), g = f_gap(a);
    int tl = 1 + l + 2 * b * h;
    run(a, 1'b0, l + 2 * b * h + tr + g + 6, inj_t, 0, '0, 1'b0);
    chk("R2", {tag, " cs rise cycle"}, rise_t[0], 1);
    chk("R2", {tag, " first edge cycle"}, edge_t[0], 1 + l + h);
    chk("R4", {tag, " edge count"}, n_edge, 2 * b);
    check_edges(tag, 0, b, 1 + l + h, h, a[4], a[5]);
    chk("R7", {tag, " deselect cycle"}, fall_t[0], tl + tr);
    chk("R8", {tag, " done cycle"}, done_t[0], tl + tr + g - 1);
    chk("R8", {tag, " done pulses"}, n_done, 1);
    chk("R6", {tag, " stray strobes"}, stray, 0);
    chk("R5", {tag, " sck idle after frame"}, int'(sck), int'(a[4]));
    chk("R12", {tag, " lsb_first held"}, int'(lsb_first), int'(a[6]));
    if (inj_t > 0) chk("R11", {tag, " select windows with ignored start"}, n_rise, 1);
  endtask

  task automatic t_gap_b2b();
    logic [30:0] a = mk(7, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 1);
    logic [30:0] b2 = mk(3, 1, 1, 1, 1, 0, 0, 1, 0, 0, 0, 0);
    int n1 = f_bits(a), h1 = f_half(a), l1 = f_lead(a), t1 = f_trail(a), g1 = f_gap(a);
    int n2 = f_bits(b2), h2 = f_half(b2), l2 = f_lead(b2), t2 = f_trail(b2), g2 = f_gap(b2);
    int d1 = 1 + l1 + 2 * n1 * h1 + t1 + g1 - 1;
    run(a, 1'b0, d1 + l2 + 2 * n2 * h2 + t2 + g2 + 8, 0, 1, b2, 1'b0);
    chk("R8", "b2b first done", done_t[0], d1);
    chk("R8", "b2b second select rise", rise_t[1], d1 + 1);
    chk("R4", "b2b total edges", n_edge, 2 * n1 + 2 * n2);
    check_edges("b2b second", 2 * n1, n2, d1 + 1 + l2 + h2, h2, 1'b1, 1'b1);
    chk("R7", "b2b second deselect", fall_t[1], d1 + 1 + l2 + 2 * n2 * h2 + t2);
    chk("R12", "b2b lsb_first", int'(lsb_first), 1);
  endtask

  task automatic t_cont_follow();
    logic [30:0] a = mk(7, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 1);
    logic [30:0] b2 = mk(4, 0, 1, 0, 1, 1, 0, 0, 2, 0, 0, 0);
    int n1 = f_bits(a), h1 = f_half(a), l1 = f_lead(a);
    int n2 = f_bits(b2), h2 = f_half(b2), t2 = f_trail(b2), g2 = f_gap(b2);
    int tl1 = 1 + l1 + 2 * n1 * h1;
    int tl2 = tl1 + 1 + 2 * n2 * h2;
    run(a, 1'b1, tl2 + t2 + g2 + 6, 0, 1, b2, 1'b0);
    chk("R9", "continuous done at last edge", done_t[0], tl1);
    chk("R9", "select windows under continuous", n_rise, 1);
    check_edges("continuous second", 2 * n1, n2, tl1 + 1 + h2, h2, 1'b0, 1'b1);
    chk("R7", "continuous second deselect", fall_t[0], tl2 + t2);
    chk("R8", "continuous second done", done_t[1], tl2 + t2 + g2 - 1);
  endtask

  task automatic t_cont_alone();
    logic [30:0] a = mk(5, 1, 0, 1, 0, 2, 1, 0, 1, 1, 0, 0);
    int n = f_bits(a), h = f_half(a), l = f_lead(a), tr = f_trail(a), g = f_gap(a);
    int tl = 1 + l + 2 * n * h;
    run(a, 1'b1, tl + tr + g + 8, 0, 0, '0, 1'b0);
    chk("R9", "held done at last edge", done_t[0], tl);
    chk("R10", "held deselect cycle", fall_t[0], tl + tr + 1);
    chk("R10", "held gap done", done_t[1], tl + tr + 1 + g - 1);
    check_edges("held", 0, n, 1 + l + h, h, 1'b1, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_single("basic", mk(7, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 1), 12);
    t_single("pol1 pha1", mk(4, 1, 1, 1, 1, 1, 1, 0, 0, 0, 2, 0), 30);
    t_single("clamped", mk(1, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0), 0);
    t_single("wide", mk(15, 1, 0, 0, 0, 4, 2, 1, 3, 0, 0, 2), 0);
    t_single("slow", mk(3, 0, 1, 1, 3, 3, 0, 3, 0, 0, 1, 0), 90);
    t_gap_b2b();
    t_cont_follow();
    t_cont_alone();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule